// File: doc/BRIEF.md
# SHA-256/224 Compression Engine

This block computes SHA-256 and SHA-224 over message blocks that software has already padded. Software reaches it through a small word-addressed register bus. It holds a sixteen-word message store, an eight-word chaining-value store, a mode register and two command words. Writing the "seed" command compresses the message store starting from the standard initial value of the selected algorithm. Writing the "chain" command compresses the message store starting from whatever the chaining-value store currently holds. The result is written back into the chaining-value store, and the digest is read from there.

Both stores can be read and written by software while the engine is idle. A partly hashed stream can therefore be parked by reading out the chaining values, and resumed later by writing them back, while other streams use the engine in between. The datapath does one round per clock. A compression keeps the busy flag high for 66 cycles: one load cycle, 64 round cycles and one fold cycle.

Top module: `sha2_engine`

## Requirements
- R1: After reset, busy is 0 and the mode register, every message word and every chaining word read as 0.
- R2: Mode code 2 selects SHA-256 and code 1 selects SHA-224. A command written while the mode holds any other code starts nothing: busy stays 0 and the chaining store is unchanged.
- R3: A command is a full-strobe write with bit 0 set, to word address 0x19 (seed) or 0x1A (chain). Busy reads 1 from the cycle after an accepted command and stays 1 for exactly 66 cycles.
- R4: A seed command leaves in the chaining store the standard initial value of the mode plus the compression of the message block. The digest is chaining words 0..7 for SHA-256 and words 0..6 for SHA-224.
- R5: A chain command compresses the message block on top of the current chaining store, so a seed followed by chains hashes a multi-block message.
- R6: While busy is 1, commands are ignored and bus writes to the message and chaining stores leave them unchanged.
- R7: The message store keeps its contents after a compression. Nothing clears it automatically.
- R8: A write whose byte strobes are not all four set has no effect on any register and does not start a command.
- R9: Chaining words written by software replace the chaining value used by the next chain command, so a saved context can be restored and finished.
- R10: Word address map: 0x00-0x0F message words W[0]..W[15] (big-endian, as SHA-2 defines them), 0x10-0x17 chaining words H0..H7, 0x18 mode (3 bits), 0x1B status (bit 0 = busy). Command addresses read 0. Read data and its valid flag appear one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte strobes; only 4'hF writes take effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| busy | output | 1 | Compression in progress |

## Verification
The hardest state to reach from the ports is the restore of a parked context. A first block is seeded and its chaining words are read out. An unrelated message then overwrites both stores through a complete compression of its own. The saved words and the second block are written back before a chain command, and the final digest must equal the standard two-block result. A second hard case is bus traffic that lands inside the busy window: a chain command and writes to both stores are issued during a seeded compression, and the bench then checks that the digest, the message word and the busy length are unaffected.

// File: rtl/sha2_pkg.sv
package sha2_pkg;
  localparam int MSG_WORDS  = 16;
  localparam int HASH_WORDS = 8;
  localparam int MI_W       = $clog2(MSG_WORDS);
  localparam int HI_W       = $clog2(HASH_WORDS);

  localparam int A_HASH  = 16;
  localparam int A_MODE  = 24;
  localparam int A_SEED  = 25;
  localparam int A_CHAIN = 26;
  localparam int A_STAT  = 27;

  localparam logic [2:0] MODE_224 = 3'd1;
  localparam logic [2:0] MODE_256 = 3'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ROUND, ST_FOLD} eng_state_e;

  localparam logic [0:63][31:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam logic [0:7][31:0] IV_256 = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  localparam logic [0:7][31:0] IV_224 = {
    32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
    32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4
  };

  function automatic logic [31:0] iv_word(input logic use224, input logic [HI_W-1:0] idx);
    return use224 ? IV_224[idx] : IV_256[idx];
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] big_s0(input logic [31:0] x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic logic [31:0] big_s1(input logic [31:0] x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic logic [31:0] sml_s0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sml_s1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [31:0] choose(input logic [31:0] e, input logic [31:0] f, input logic [31:0] g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic logic [31:0] major(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha2_regfile.sv
module sha2_regfile
  import sha2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MODE_W = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_full,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [31:0]                      wr_data,
  input  logic                             rd_req,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic                             eng_busy,
  input  logic                             fold_we,
  input  logic [HASH_WORDS-1:0][31:0]      fold_words,
  output logic [MSG_WORDS-1:0][31:0]       msg_words,
  output logic [HASH_WORDS-1:0][31:0]      hash_words,
  output logic [MODE_W-1:0]                mode_q,
  output logic [31:0]                      rd_data,
  output logic                             rd_valid
);
  localparam logic [ADDR_W-1:0] AD_HASH = ADDR_W'(A_HASH);
  localparam logic [ADDR_W-1:0] AD_HEND = ADDR_W'(A_HASH + HASH_WORDS);
  localparam logic [ADDR_W-1:0] AD_MEND = ADDR_W'(MSG_WORDS);
  localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
  localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);

  logic wr_open;
  logic wr_msg, wr_hash;
  logic rd_msg, rd_hash;

  assign wr_open = wr_full && !eng_busy;
  assign wr_msg  = wr_open && (wr_addr < AD_MEND);
  assign wr_hash = wr_open && (wr_addr >= AD_HASH) && (wr_addr < AD_HEND);
  assign rd_msg  = rd_addr < AD_MEND;
  assign rd_hash = (rd_addr >= AD_HASH) && (rd_addr < AD_HEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_words <= '0;
    end else begin
      for (int i = 0; i < MSG_WORDS; i++) begin
        if (wr_msg && wr_addr[MI_W-1:0] == MI_W'(i)) msg_words[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_words <= '0;
    end else if (fold_we) begin
      hash_words <= fold_words;
    end else begin
      for (int i = 0; i < HASH_WORDS; i++) begin
        if (wr_hash && wr_addr[HI_W-1:0] == HI_W'(i)) hash_words[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_full && wr_addr == AD_MODE) begin
      mode_q <= wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (rd_msg)                  rd_data <= msg_words[rd_addr[MI_W-1:0]];
        else if (rd_hash)            rd_data <= hash_words[rd_addr[HI_W-1:0]];
        else if (rd_addr == AD_MODE) rd_data <= {{(32-MODE_W){1'b0}}, mode_q};
        else if (rd_addr == AD_STAT) rd_data <= {31'b0, eng_busy};
        else                         rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/sha2_sched.sv
module sha2_sched
  import sha2_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        step,
  input  logic [MSG_WORDS-1:0][31:0]  blk,
  output logic [31:0]                 w_cur
);
  logic [MSG_WORDS-1:0][31:0] win_q;
  logic [31:0]                w_new;

  assign w_new = sml_s1(win_q[14]) + win_q[9] + sml_s0(win_q[1]) + win_q[0];
  assign w_cur = win_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (load) begin
      win_q <= blk;
    end else if (step) begin
      for (int i = 0; i < MSG_WORDS - 1; i++) win_q[i] <= win_q[i+1];
      win_q[MSG_WORDS-1] <= w_new;
    end
  end
endmodule

// File: rtl/sha2_round_dp.sv
module sha2_round_dp
  import sha2_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         step,
  input  logic [HASH_WORDS-1:0][31:0]  init,
  input  logic [31:0]                  k_t,
  input  logic [31:0]                  w_t,
  output logic [HASH_WORDS-1:0][31:0]  vars
);
  logic [31:0] t1, t2;

  assign t1 = vars[7] + big_s1(vars[4]) + choose(vars[4], vars[5], vars[6]) + k_t + w_t;
  assign t2 = big_s0(vars[0]) + major(vars[0], vars[1], vars[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      vars <= '0;
    end else if (load) begin
      vars <= init;
    end else if (step) begin
      vars[0] <= t1 + t2;
      vars[1] <= vars[0];
      vars[2] <= vars[1];
      vars[3] <= vars[2];
      vars[4] <= vars[3] + t1;
      vars[5] <= vars[4];
      vars[6] <= vars[5];
      vars[7] <= vars[6];
    end
  end
endmodule

// File: rtl/sha2_engine.sv
module sha2_engine
  import sha2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MODE_W = 3,
  parameter int ROUNDS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              busy
);
  localparam int RND_W = $clog2(ROUNDS);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(ROUNDS - 1);
  localparam logic [ADDR_W-1:0] AD_SEED  = ADDR_W'(A_SEED);
  localparam logic [ADDR_W-1:0] AD_CHAIN = ADDR_W'(A_CHAIN);

  eng_state_e                   state_q;
  logic [RND_W-1:0]             rnd_q;
  logic                         from_iv_q, sel224_q;
  logic [HASH_WORDS-1:0][31:0]  base_q, seed, vars, fold_words, hash_words;
  logic [MSG_WORDS-1:0][31:0]   msg_words;
  logic [MODE_W-1:0]            mode_q;
  logic [31:0]                  w_cur;
  logic                         wr_full, go_seed, go_chain, mode_ok, accept;

  assign wr_full  = bus_en && bus_we && (bus_be == 4'hF);
  assign go_seed  = wr_full && bus_addr == AD_SEED && bus_wdata[0];
  assign go_chain = wr_full && bus_addr == AD_CHAIN && bus_wdata[0];
  assign mode_ok  = (mode_q == MODE_W'(MODE_224)) || (mode_q == MODE_W'(MODE_256));
  assign accept   = (go_seed || go_chain) && state_q == ST_IDLE && mode_ok;
  assign busy     = state_q != ST_IDLE;

  for (genvar i = 0; i < HASH_WORDS; i++) begin : g_word
    assign seed[i]       = from_iv_q ? iv_word(sel224_q, HI_W'(i)) : hash_words[i];
    assign fold_words[i] = base_q[i] + vars[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rnd_q     <= '0;
      from_iv_q <= 1'b0;
      sel224_q  <= 1'b0;
      base_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_LOAD;
          from_iv_q <= go_seed;
          sel224_q  <= mode_q == MODE_W'(MODE_224);
        end
        ST_LOAD: begin
          base_q  <= seed;
          rnd_q   <= '0;
          state_q <= ST_ROUND;
        end
        ST_ROUND: begin
          rnd_q <= rnd_q + 1'b1;
          if (rnd_q == RND_LAST) state_q <= ST_FOLD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sha2_regfile #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .wr_full    (wr_full),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .rd_req     (bus_en && !bus_we),
    .rd_addr    (bus_addr),
    .eng_busy   (busy),
    .fold_we    (state_q == ST_FOLD),
    .fold_words (fold_words),
    .msg_words  (msg_words),
    .hash_words (hash_words),
    .mode_q     (mode_q),
    .rd_data    (bus_rdata),
    .rd_valid   (bus_rvalid)
  );

  sha2_sched u_sched (
    .clk   (clk),
    .rst   (rst),
    .load  (state_q == ST_LOAD),
    .step  (state_q == ST_ROUND),
    .blk   (msg_words),
    .w_cur (w_cur)
  );

  sha2_round_dp u_dp (
    .clk  (clk),
    .rst  (rst),
    .load (state_q == ST_LOAD),
    .step (state_q == ST_ROUND),
    .init (seed),
    .k_t  (K_TAB[rnd_q]),
    .w_t  (w_cur),
    .vars (vars)
  );
endmodule

// File: rtl/sha2_engine_chk.sv
module sha2_engine_chk
  import sha2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int MODE_W = 3,
  parameter int ROUNDS = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_en,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [3:0]                  bus_be,
  input logic                        strobe_bit,
  input logic                        busy,
  input logic [MODE_W-1:0]           mode_q,
  input logic [MSG_WORDS-1:0][31:0]  msg_words,
  input logic [HASH_WORDS-1:0][31:0] hash_words
);
  logic        full_w, kick, mode_good, hash_wr, part_w;
  logic [15:0] busy_len;

  assign full_w    = bus_en && bus_we && bus_be == 4'hF;
  assign part_w    = bus_en && bus_we && bus_be != 4'hF;
  assign kick      = full_w && strobe_bit &&
                     (bus_addr == ADDR_W'(A_SEED) || bus_addr == ADDR_W'(A_CHAIN));
  assign mode_good = mode_q == MODE_W'(1) || mode_q == MODE_W'(2);
  assign hash_wr   = full_w && bus_addr >= ADDR_W'(A_HASH) &&
                     bus_addr < ADDR_W'(A_HASH + HASH_WORDS);

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    kick && !busy && mode_good |=> busy);

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(kick));

  // R2
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    kick && !busy && !mode_good |=> !busy);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_len == 16'(ROUNDS + 2));

  // R6
  msg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(msg_words));

  // R8
  part_wr_chk: assert property (@(posedge clk) disable iff (rst)
    part_w && !busy |=> $stable(msg_words) && $stable(hash_words) && $stable(mode_q) && !busy);

  // R6
  hash_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(hash_words) |-> $past(busy) || $past(hash_wr));
endmodule

bind sha2_engine sha2_engine_chk #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .ROUNDS(ROUNDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .strobe_bit (bus_wdata[0]),
  .busy       (busy),
  .mode_q     (mode_q),
  .msg_words  (msg_words),
  .hash_words (hash_words)
);

// File: tb/sim_sha2_engine.sv
`timescale 1ns/1ps
module sim_sha2_engine;
  localparam int ADDR_W = 6;
  localparam logic [5:0] AM = 6'h18, AS = 6'h19, AC = 6'h1A, AT = 6'h1B, AH = 6'h10;

  // {message kind[1:0], mode[2:0], digest[255:0]}; kind 0 empty, 1 "abc", 2 two-block
  localparam logic [260:0] VECS [6] = '{
    {2'd0, 3'd2, 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855},
    {2'd0, 3'd1, 256'hd14a028c2a3a2bc9476102bb288234c415a2b01f828ea62ac5b3e42f00000000},
    {2'd1, 3'd2, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad},
    {2'd1, 3'd1, 256'h23097d223405d8228642a477bda255b32aadbce4bda0b3f7e36c9da700000000},
    {2'd2, 3'd2, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1},
    {2'd2, 3'd1, 256'h75388b16512776cc5dba5da1fd890150b0c6455cb4f58b195252252500000000}
  };
  localparam logic [255:0] D2_256 = VECS[4][255:0];
  localparam logic [255:0] D1_256 = VECS[2][255:0];

  logic clk = 1'b0, rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, busy;
  int checks = 0, errors = 0;
  logic last_rv;

  always #2.5 clk = ~clk;

  sha2_engine #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .busy(busy)
  );

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
    last_rv = bus_rvalid;
  endtask

  function automatic logic [31:0] blk_word(input int kind, input int part, input int i);
    if (kind == 0) return (i == 0) ? 32'h80000000 : 32'h0;
    if (kind == 1) return (i == 0) ? 32'h61626380 : (i == 15) ? 32'h18 : 32'h0;
    if (part == 1) return (i == 15) ? 32'h1c0 : 32'h0;
    if (i < 14) return {8'(8'h61 + i), 8'(8'h62 + i), 8'(8'h63 + i), 8'(8'h64 + i)};
    return (i == 14) ? 32'h80000000 : 32'h0;
  endfunction

  task automatic put_block(input int kind, input int part);
    for (int i = 0; i < 16; i++) wr(6'(i), blk_word(kind, part, i));
  endtask

  task automatic run(input logic [5:0] cmd, output int n);
    wr(cmd, 32'h1);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_digest(input string req, input logic [255:0] dg, input int nw);
    logic [31:0] v;
    for (int j = 0; j < nw; j++) begin
      rd(AH + 6'(j), v);
      chk(req, v, dg[255 - 32*j -: 32]);
    end
  endtask

  initial begin
    logic [31:0] v, h0;
    logic [255:0] saved;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'h0);
    rd(AM, v); chk("R1 mode", v, 32'h0);
    rd(6'h00, v); chk("R1 msg0", v, 32'h0);
    rd(AH, v); chk("R1 hash0", v, 32'h0);
    chk("R10 rvalid", {31'b0, last_rv}, 32'h1);

    // R4 R5 R2 table of standard digests
    for (int e = 0; e < 6; e++) begin
      int kind, nw;
      kind = int'(VECS[e][260:259]);
      nw = (VECS[e][258:256] == 3'd1) ? 7 : 8;
      wr(AM, {29'b0, VECS[e][258:256]});
      put_block(kind, 0);
      run(AS, n);
      chk("R3 busy length", 32'(n), 32'd66);
      if (kind == 2) begin
        put_block(2, 1);
        run(AC, n);
      end
      cmp_digest(kind == 2 ? "R5 R2 chained digest" : "R4 R2 seeded digest", VECS[e][255:0], nw);
    end

    // R7 message store retained after compression
    for (int i = 0; i < 16; i++) begin
      rd(6'(i), v);
      chk("R7 msg kept", v, blk_word(2, 1, i));
    end

    // R2 unsupported mode: command ignored
    rd(AH, h0);
    wr(AM, 32'h3);
    wr(AS, 32'h1);
    chk("R2 bad mode busy", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk("R2 bad mode busy later", {31'b0, busy}, 32'h0);
    rd(AH, v); chk("R2 hash unchanged", v, h0);

    // R8 partial strobes ignored
    wr(AM, 32'h2);
    wr(6'h00, 32'hdeadbeef, 4'h3);
    rd(6'h00, v); chk("R8 msg partial", v, blk_word(2, 1, 0));
    wr(AH, 32'h12345678, 4'hE);
    rd(AH, v); chk("R8 hash partial", v, h0);
    wr(AM, 32'h1, 4'h1);
    rd(AM, v); chk("R8 mode partial", v, 32'h2);
    wr(AS, 32'h1, 4'h1);
    chk("R8 command partial", {31'b0, busy}, 32'h0);

    // R6 traffic inside busy window
    put_block(1, 0);
    wr(AS, 32'h1);
    chk("R3 busy next cycle", {31'b0, busy}, 32'h1);
    rd(AT, v); chk("R10 status busy", v, 32'h1);
    rd(AS, v); chk("R10 command reads 0", v, 32'h0);
    wr(AC, 32'h1);
    wr(6'h00, 32'hcafef00d);
    wr(AH + 6'd3, 32'h0badf00d);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 no restart", {31'b0, busy}, 32'h0);
    rd(6'h00, v); chk("R6 msg write ignored", v, 32'h61626380);
    cmp_digest("R6 digest intact", D1_256, 8);

    // R9 save, interleave, restore
    put_block(2, 0);
    run(AS, n);
    for (int j = 0; j < 8; j++) begin
      rd(AH + 6'(j), v);
      saved[255 - 32*j -: 32] = v;
    end
    put_block(1, 0);
    run(AS, n);
    cmp_digest("R9 interleaved digest", D1_256, 1);
    for (int j = 0; j < 8; j++) wr(AH + 6'(j), saved[255 - 32*j -: 32]);
    put_block(2, 1);
    run(AC, n);
    cmp_digest("R9 restored chain", D2_256, 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule